// File: doc/BRIEF.md
# Paced Memory-to-Memory Transfer Channel

This block is a single transfer channel for peripherals that move data in bursts. Software programs a source start address, a destination start address, a transfer count and a pacing word, then sets the start bit. The channel reads one data unit from the source and writes it to the destination. It repeats this until the programmed count is used up. Each unit is one `DW`-bit word. A linear side advances its address by `DW/8` bytes per unit, and a fixed side keeps its address.

Each side is paced by its own peripheral request line. When a side has no units left in its current block, it waits for its request before it starts a new block. A block is a programmable number of units. Once the last unit of a block is done, that side stays quiet for a programmed number of idle cycles before it accepts the next request.

A busy flag, separate from the start bit, shows when the channel is actually moving data. Two one-cycle events mark the midpoint and the end of each pass. In continuous mode the channel reloads its registers and starts again after each pass.

Top module: `paced_dma_chan`

## Requirements
- R1: The register map is 0x00 control, 0x04 source start, 0x08 destination start, 0x0C count (14 bits, upper bits read 0) and 0x18 pacing. The pacing word holds destination block size in 31:24, destination idle cycles in 23:16, source block size in 15:8 and source idle cycles in 7:0. The control word holds start in 31, read-only busy in 30, continuous in 29, destination mode in 22:21, destination request type in 20:16 and source mode in 6:5. All other control bits read 0. Every register resets to 0.
- R2: While start is set, writes to the address, count and pacing registers are ignored. A control write while start is set changes only the continuous bit.
- R3: A pass moves `count` units, each read then written. Mode 0 (linear) steps the side's address by 4 per unit. Mode 1 (fixed) holds it. Written data equals the data read.
- R4: On the source side, a new block starts only while the source request is high. The block holds the source block size in units, and a size of 0 counts as 1. After its last read is accepted, the source side issues no read for exactly the source idle-cycle count.
- R5: The destination side follows the same block and idle rule with its own request, block size and idle count.
- R6: Busy stays low after start until the first read is issued. It stays high until the last write of the pass is accepted. At that point start clears unless continuous mode is set.
- R7: In continuous mode the channel reloads the programmed registers and runs another pass. A control write in the same cycle as the final write acceptance decides the continuous bit used for that decision.
- R8: `done_evt` pulses for one cycle, one cycle after the final write acceptance. When count is at least 2, `half_evt` pulses one cycle after the write that completes count/2 units.
- R9: A control write that sets start with mode 2 or 3 in either mode field does not set start. It sets `mode_err`, which holds until the next control write.
- R10: Starting with a count of 0 clears start on the next cycle, with no access and no `done_evt`.
- R11: `rd_valid` and `wr_valid` are never high together. Each stays high with a stable address (and stable data for writes) until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| src_req | input | 1 | Source peripheral request |
| dst_req | input | 1 | Destination peripheral request |
| rd_valid | output | 1 | Read access pending |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read accepted, `rd_data` valid |
| rd_data | input | DW | Read data |
| wr_valid | output | 1 | Write access pending |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Write data |
| wr_ack | input | 1 | Write accepted |
| done_evt | output | 1 | End-of-pass pulse |
| half_evt | output | 1 | Midpoint pulse |
| mode_err | output | 1 | Unsupported address mode requested |

## Verification
The delicate overlap is a software control write that lands in the same clock edge as the final write acceptance of a continuous pass. Completion and the register update then compete for the start bit. The bench arms its memory model to raise the control write, which clears continuous, exactly when it acknowledges the last write of the first pass. The run is judged correct only if exactly one end-of-pass event appears, no further write arrives at the scoreboard, and start reads back as clear.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RGATE = 3'd1,
        ST_RD    = 3'd2,
        ST_WGATE = 3'd3,
        ST_WR    = 3'd4
    } eng_st_e;

    // register byte offsets
    localparam int OFS_CTRL = 'h00;
    localparam int OFS_SRC  = 'h04;
    localparam int OFS_DST  = 'h08;
    localparam int OFS_CNT  = 'h0C;
    localparam int OFS_PACE = 'h18;

    // control word bit positions
    localparam int CTL_START    = 31;
    localparam int CTL_BUSY     = 30;
    localparam int CTL_CONT     = 29;
    localparam int CTL_DMODE_LO = 21;
    localparam int CTL_DREQ_LO  = 16;
    localparam int CTL_SMODE_LO = 5;

    // pacing word field positions
    localparam int PF_W       = 8;
    localparam int PC_SWAIT   = 0;
    localparam int PC_SBLK    = 8;
    localparam int PC_DWAIT   = 16;
    localparam int PC_DBLK    = 24;

    localparam logic [1:0] AM_LINEAR = 2'd0;

endpackage

// File: rtl/dmac_pacer.sv
module dmac_pacer #(
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          req,
    input  logic          unit,
    input  logic [FW-1:0] blk,
    input  logic [FW-1:0] wcyc,
    output logic          grant
);

    typedef struct packed {
        logic [FW-1:0] credit;
        logic [FW-1:0] wt;
    } pace_t;

    pace_t p_d, p_q;
    logic [FW-1:0] blk_eff;
    logic [FW-1:0] credit_nxt;

    assign blk_eff = (blk == '0) ? FW'(1) : blk;
    assign grant   = (p_q.credit != '0) || ((p_q.wt == '0) && req);

    always_comb begin
        p_d        = p_q;
        credit_nxt = ((p_q.credit != '0) ? p_q.credit : blk_eff) - FW'(1);
        if (p_q.wt != '0) begin
            p_d.wt = p_q.wt - FW'(1);
        end
        if (clear) begin
            p_d.credit = '0;
        end
        if (unit) begin
            p_d.credit = credit_nxt;
            if (credit_nxt == '0) begin
                p_d.wt = wcyc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int AW  = 32,
    parameter int CW  = 14,
    parameter int RAW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [RAW-1:0] addr,
    input  logic [31:0]    wdata,
    output logic [31:0]    rdata,
    input  logic           busy,
    input  logic           pass_end,
    output logic           start,
    output logic           cont,
    output logic [1:0]     smode,
    output logic [1:0]     dmode,
    output logic [AW-1:0]  src_base,
    output logic [AW-1:0]  dst_base,
    output logic [CW-1:0]  count,
    output logic [PF_W-1:0] sblk,
    output logic [PF_W-1:0] swait,
    output logic [PF_W-1:0] dblk,
    output logic [PF_W-1:0] dwait,
    output logic           mode_err
);

    typedef struct packed {
        logic          start;
        logic          cont;
        logic [1:0]    dmode;
        logic [4:0]    dreq;
        logic [1:0]    smode;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic [31:0]   pace;
        logic          merr;
    } regs_t;

    regs_t r_d, r_q;
    logic  page_req;

    always_comb begin
        r_d      = r_q;
        page_req = 1'b0;
        if (we) begin
            if (addr == RAW'(OFS_CTRL)) begin
                r_d.merr = 1'b0;
                if (r_q.start) begin
                    r_d.cont = wdata[CTL_CONT];
                end else begin
                    // mode codes 2 and 3 have their upper bit set
                    page_req  = wdata[CTL_DMODE_LO+1] | wdata[CTL_SMODE_LO+1];
                    r_d.start = wdata[CTL_START] & ~page_req;
                    r_d.merr  = wdata[CTL_START] & page_req;
                    r_d.cont  = wdata[CTL_CONT];
                    r_d.dmode = wdata[CTL_DMODE_LO +: 2];
                    r_d.dreq  = wdata[CTL_DREQ_LO +: 5];
                    r_d.smode = wdata[CTL_SMODE_LO +: 2];
                end
            end else if (!r_q.start) begin
                if (addr == RAW'(OFS_SRC))  r_d.src  = wdata[AW-1:0];
                if (addr == RAW'(OFS_DST))  r_d.dst  = wdata[AW-1:0];
                if (addr == RAW'(OFS_CNT))  r_d.cnt  = wdata[CW-1:0];
                if (addr == RAW'(OFS_PACE)) r_d.pace = wdata;
            end
        end
        // end of pass uses the continuous bit as updated this cycle
        if (pass_end && !r_d.cont) begin
            r_d.start = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == RAW'(OFS_CTRL)) begin
            rdata[CTL_START]           = r_q.start;
            rdata[CTL_BUSY]            = busy;
            rdata[CTL_CONT]            = r_q.cont;
            rdata[CTL_DMODE_LO +: 2]   = r_q.dmode;
            rdata[CTL_DREQ_LO +: 5]    = r_q.dreq;
            rdata[CTL_SMODE_LO +: 2]   = r_q.smode;
        end else if (addr == RAW'(OFS_SRC)) begin
            rdata = 32'(r_q.src);
        end else if (addr == RAW'(OFS_DST)) begin
            rdata = 32'(r_q.dst);
        end else if (addr == RAW'(OFS_CNT)) begin
            rdata = 32'(r_q.cnt);
        end else if (addr == RAW'(OFS_PACE)) begin
            rdata = r_q.pace;
        end
    end

    assign start    = r_q.start;
    assign cont     = r_q.cont;
    assign smode    = r_q.smode;
    assign dmode    = r_q.dmode;
    assign src_base = r_q.src;
    assign dst_base = r_q.dst;
    assign count    = r_q.cnt;
    assign sblk     = r_q.pace[PC_SBLK  +: PF_W];
    assign swait    = r_q.pace[PC_SWAIT +: PF_W];
    assign dblk     = r_q.pace[PC_DBLK  +: PF_W];
    assign dwait    = r_q.pace[PC_DWAIT +: PF_W];
    assign mode_err = r_q.merr;

endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
    import dmac_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] count,
    input  logic [AW-1:0] src_base,
    input  logic [AW-1:0] dst_base,
    input  logic [1:0]    smode,
    input  logic [1:0]    dmode,
    input  logic          sgrant,
    input  logic          dgrant,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    input  logic          wr_ack,
    output logic          rd_valid,
    output logic [AW-1:0] rd_addr,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          busy,
    output logic          pass_end,
    output logic          load,
    output logic          s_unit,
    output logic          d_unit,
    output logic          done_evt,
    output logic          half_evt
);

    localparam int STEP = DW / 8;

    typedef struct packed {
        eng_st_e       st;
        logic          busy;
        logic [AW-1:0] sa;
        logic [AW-1:0] da;
        logic [CW-1:0] left;
        logic [CW-1:0] total;
        logic [DW-1:0] data;
        logic          done;
        logic          half;
    } eng_t;

    eng_t e_d, e_q;

    always_comb begin
        e_d      = e_q;
        e_d.done = 1'b0;
        e_d.half = 1'b0;
        pass_end = 1'b0;
        load     = 1'b0;
        s_unit   = 1'b0;
        d_unit   = 1'b0;
        case (e_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (count == '0) begin
                        pass_end = 1'b1;
                    end else begin
                        e_d.sa    = src_base;
                        e_d.da    = dst_base;
                        e_d.left  = count;
                        e_d.total = count;
                        e_d.st    = ST_RGATE;
                        load      = 1'b1;
                    end
                end
            end
            ST_RGATE: begin
                if (sgrant) begin
                    e_d.st   = ST_RD;
                    e_d.busy = 1'b1;
                end
            end
            ST_RD: begin
                if (rd_ack) begin
                    e_d.data = rd_data;
                    s_unit   = 1'b1;
                    if (smode == AM_LINEAR) begin
                        e_d.sa = e_q.sa + AW'(STEP);
                    end
                    e_d.st = ST_WGATE;
                end
            end
            ST_WGATE: begin
                if (dgrant) begin
                    e_d.st = ST_WR;
                end
            end
            ST_WR: begin
                if (wr_ack) begin
                    d_unit   = 1'b1;
                    e_d.left = e_q.left - CW'(1);
                    if (dmode == AM_LINEAR) begin
                        e_d.da = e_q.da + AW'(STEP);
                    end
                    if ((e_q.total >= CW'(2)) &&
                        ((e_q.total - e_d.left) == (e_q.total >> 1))) begin
                        e_d.half = 1'b1;
                    end
                    if (e_q.left == CW'(1)) begin
                        e_d.done = 1'b1;
                        e_d.busy = 1'b0;
                        pass_end = 1'b1;
                        e_d.st   = ST_IDLE;
                    end else begin
                        e_d.st = ST_RGATE;
                    end
                end
            end
            default: e_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '{st: ST_IDLE, default: '0};
        end else begin
            e_q <= e_d;
        end
    end

    assign rd_valid = (e_q.st == ST_RD);
    assign rd_addr  = e_q.sa;
    assign wr_valid = (e_q.st == ST_WR);
    assign wr_addr  = e_q.da;
    assign wr_data  = e_q.data;
    assign busy     = e_q.busy;
    assign done_evt = e_q.done;
    assign half_evt = e_q.half;

endmodule

// File: rtl/paced_dma_chan.sv
module paced_dma_chan
    import dmac_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int CW  = 14,
    parameter int RAW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [RAW-1:0] reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    input  logic           src_req,
    input  logic           dst_req,
    output logic           rd_valid,
    output logic [AW-1:0]  rd_addr,
    input  logic           rd_ack,
    input  logic [DW-1:0]  rd_data,
    output logic           wr_valid,
    output logic [AW-1:0]  wr_addr,
    output logic [DW-1:0]  wr_data,
    input  logic           wr_ack,
    output logic           done_evt,
    output logic           half_evt,
    output logic           mode_err
);

    localparam int NSIDE = 2;   // 0 = source, 1 = destination

    logic            cfg_start, cfg_cont;
    logic [1:0]      cfg_smode, cfg_dmode;
    logic [AW-1:0]   cfg_src, cfg_dst;
    logic [CW-1:0]   cfg_cnt;
    logic [PF_W-1:0] cfg_sblk, cfg_swait, cfg_dblk, cfg_dwait;
    logic            eng_busy, eng_pass_end, eng_load;

    logic [NSIDE-1:0] side_req, side_unit, side_grant;
    logic [PF_W-1:0]  side_blk  [NSIDE];
    logic [PF_W-1:0]  side_wait [NSIDE];

    dmac_regs #(.AW(AW), .CW(CW), .RAW(RAW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .busy     (eng_busy),
        .pass_end (eng_pass_end),
        .start    (cfg_start),
        .cont     (cfg_cont),
        .smode    (cfg_smode),
        .dmode    (cfg_dmode),
        .src_base (cfg_src),
        .dst_base (cfg_dst),
        .count    (cfg_cnt),
        .sblk     (cfg_sblk),
        .swait    (cfg_swait),
        .dblk     (cfg_dblk),
        .dwait    (cfg_dwait),
        .mode_err (mode_err)
    );

    assign side_req[0]  = src_req;
    assign side_req[1]  = dst_req;
    assign side_blk[0]  = cfg_sblk;
    assign side_blk[1]  = cfg_dblk;
    assign side_wait[0] = cfg_swait;
    assign side_wait[1] = cfg_dwait;

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        dmac_pacer #(.FW(PF_W)) u_pacer (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (eng_load),
            .req   (side_req[g]),
            .unit  (side_unit[g]),
            .blk   (side_blk[g]),
            .wcyc  (side_wait[g]),
            .grant (side_grant[g])
        );
    end

    dmac_engine #(.AW(AW), .DW(DW), .CW(CW)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cfg_start),
        .count    (cfg_cnt),
        .src_base (cfg_src),
        .dst_base (cfg_dst),
        .smode    (cfg_smode),
        .dmode    (cfg_dmode),
        .sgrant   (side_grant[0]),
        .dgrant   (side_grant[1]),
        .rd_ack   (rd_ack),
        .rd_data  (rd_data),
        .wr_ack   (wr_ack),
        .rd_valid (rd_valid),
        .rd_addr  (rd_addr),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .busy     (eng_busy),
        .pass_end (eng_pass_end),
        .load     (eng_load),
        .s_unit   (side_unit[0]),
        .d_unit   (side_unit[1]),
        .done_evt (done_evt),
        .half_evt (half_evt)
    );

endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_valid,
    input logic          rd_ack,
    input logic [AW-1:0] rd_addr,
    input logic          wr_valid,
    input logic          wr_ack,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          done_evt,
    input logic          half_evt,
    input logic          mode_err,
    input logic          busy,
    input logic          start
);

    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && wr_valid));                                   // R11
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ack) |=> (rd_valid && $stable(rd_addr)));  // R11
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ack) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R11
    AST_ACCESS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid || wr_valid) |-> busy);                           // R6
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> start);                                            // R6
    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |-> ($past(wr_ack) && !busy));                     // R8
    AST_EVT_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_evt && half_evt));                                   // R8
    AST_PAGE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> !start);                                       // R9

endmodule

bind paced_dma_chan dmac_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_valid (rd_valid),
    .rd_ack   (rd_ack),
    .rd_addr  (rd_addr),
    .wr_valid (wr_valid),
    .wr_ack   (wr_ack),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .done_evt (done_evt),
    .half_evt (half_evt),
    .mode_err (mode_err),
    .busy     (eng_busy),
    .start    (cfg_start)
);

// File: tb/paced_dma_chan_tb_top.sv
`timescale 1ns/1ps
module paced_dma_chan_tb_top;

    localparam int AW  = 32;
    localparam int DW  = 32;
    localparam int RAW = 5;
    localparam logic [31:0] MASK = 32'h5A5A_0000;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic           rst_n;
    logic           reg_we;
    logic [RAW-1:0] reg_addr;
    logic [31:0]    reg_wdata, reg_rdata;
    logic           src_req, dst_req;
    logic           rd_valid, rd_ack, wr_valid, wr_ack;
    logic [AW-1:0]  rd_addr, wr_addr;
    logic [DW-1:0]  rd_data, wr_data;
    logic           done_evt, half_evt, mode_err;

    logic           t_we = 1'b0, coll_we = 1'b0;
    logic [RAW-1:0] t_addr = '0;
    logic [31:0]    t_wd = '0;

    assign reg_we    = t_we | coll_we;
    assign reg_addr  = coll_we ? '0 : t_addr;
    assign reg_wdata = coll_we ? '0 : t_wd;

    paced_dma_chan dut_i (.*);

    typedef struct { logic [31:0] a; logic [31:0] d; } wr_item_t;
    wr_item_t exp_q[$];
    wr_item_t mon_it;
    int rd_t[$], wr_t[$];
    logic [31:0] rd_a[$];
    int n_chk = 0, n_fail = 0, cyc = 0;
    int done_cnt = 0, half_cnt = 0, done_t = 0, half_t = 0, overlap = 0;
    bit coll_arm = 1'b0;

    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model and scoreboard monitor
    initial begin
        rd_ack = 1'b0; wr_ack = 1'b0; rd_data = '0;
    end
    always @(negedge clk) begin
        if (rst_n) begin
            coll_we = 1'b0;
            if (rd_valid && wr_valid) overlap++;
            if (rd_valid && !rd_ack) begin
                rd_ack  = 1'b1;
                rd_data = rd_addr ^ MASK;
                rd_t.push_back(cyc);
                rd_a.push_back(rd_addr);
            end else begin
                rd_ack = 1'b0;
            end
            if (wr_valid && !wr_ack) begin
                wr_ack = 1'b1;
                wr_t.push_back(cyc);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected write", wr_addr, 32'h0);
                end else begin
                    mon_it = exp_q.pop_front();
                    check(wr_addr == mon_it.a, "R3 write address", wr_addr, mon_it.a);
                    check(wr_data == mon_it.d, "R3 write data", wr_data, mon_it.d);
                    if (coll_arm && exp_q.size() == 0) begin
                        coll_we  = 1'b1;
                        coll_arm = 1'b0;
                    end
                end
            end else begin
                wr_ack = 1'b0;
            end
            if (done_evt) begin done_cnt++; done_t = cyc; end
            if (half_evt) begin half_cnt++; half_t = cyc; end
        end
    end

    task automatic reg_wr(input logic [RAW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        t_we = 1'b1; t_addr = a; t_wd = d;
        @(negedge clk);
        t_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [RAW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        t_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic push_expect(input logic [31:0] s, input logic [31:0] dd, input int n,
                               input logic [1:0] sm, input logic [1:0] dm);
        for (int i = 0; i < n; i++) begin
            wr_item_t it;
            it.a = dd + ((dm == 2'd0) ? 32'(4 * i) : 32'h0);
            it.d = (s + ((sm == 2'd0) ? 32'(4 * i) : 32'h0)) ^ MASK;
            exp_q.push_back(it);
        end
    endtask

    task automatic start_xfer(input logic [31:0] s, input logic [31:0] dd, input int n,
                              input logic [1:0] sm, input logic [1:0] dm,
                              input logic [31:0] pace, input bit cont);
        reg_wr(5'h04, s);
        reg_wr(5'h08, dd);
        reg_wr(5'h0C, 32'(n));
        reg_wr(5'h18, pace);
        rd_t.delete(); wr_t.delete(); rd_a.delete();
        reg_wr(5'h00, 32'h8000_0000 | (32'(cont) << 29) | (32'(dm) << 21) | (32'(sm) << 5));
    endtask

    task automatic wait_done(input int tgt);
        while (done_cnt < tgt) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int base;
        rst_n = 1'b0; src_req = 1'b0; dst_req = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        reg_rd(5'h00, v); check(v == 0, "R1 reset ctrl", v, 0);
        reg_rd(5'h04, v); check(v == 0, "R1 reset src", v, 0);
        reg_rd(5'h0C, v); check(v == 0, "R1 reset count", v, 0);
        reg_rd(5'h18, v); check(v == 0, "R1 reset pacing", v, 0);
        check(!mode_err && !rd_valid && !wr_valid, "R1 reset outputs", {mode_err, rd_valid, wr_valid}, 0);

        // R1 readback
        reg_wr(5'h04, 32'h1234_5678); reg_rd(5'h04, v); check(v == 32'h1234_5678, "R1 src readback", v, 32'h1234_5678);
        reg_wr(5'h0C, 32'h0000_FFFF); reg_rd(5'h0C, v); check(v == 32'h3FFF, "R1 count width", v, 32'h3FFF);
        reg_wr(5'h18, 32'h0A0B_0C0D); reg_rd(5'h18, v); check(v == 32'h0A0B_0C0D, "R1 pacing readback", v, 32'h0A0B_0C0D);
        reg_wr(5'h00, 32'h3FFF_7FFF & 32'h2035_0020 | 32'h0100_0000);
        reg_rd(5'h00, v); check(v == 32'h2035_0020, "R1 ctrl fields", v, 32'h2035_0020);
        reg_wr(5'h00, 32'h0);

        src_req = 1'b1; dst_req = 1'b1;

        // R3 / R8 linear to linear, blocks and waits
        base = done_cnt;
        push_expect(32'h100, 32'h800, 6, 2'd0, 2'd0);
        start_xfer(32'h100, 32'h800, 6, 2'd0, 2'd0, 32'h0302_0203, 1'b0);
        wait_done(base + 1);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R3 all writes seen", exp_q.size(), 0);
        check(half_cnt == 1, "R8 half count", half_cnt, 1);
        check(done_t == wr_t[5] + 1, "R8 done timing", done_t, wr_t[5] + 1);
        check(half_t == wr_t[2] + 1, "R8 half timing", half_t, wr_t[2] + 1);
        reg_rd(5'h00, v); check(v[31:30] == 2'b00, "R6 start and busy clear", v[31:30], 0);

        // R3 fixed source
        base = done_cnt;
        push_expect(32'h200, 32'hA00, 3, 2'd1, 2'd0);
        start_xfer(32'h200, 32'hA00, 3, 2'd1, 2'd0, 32'h0, 1'b0);
        wait_done(base + 1);
        check(rd_a.size() == 3 && rd_a[2] == 32'h200, "R3 fixed source address", rd_a[2], 32'h200);

        // R3 fixed destination
        base = done_cnt;
        push_expect(32'h300, 32'hB00, 3, 2'd0, 2'd1);
        start_xfer(32'h300, 32'hB00, 3, 2'd0, 2'd1, 32'h0, 1'b0);
        wait_done(base + 1);
        check(rd_a[2] == 32'h308, "R3 linear source address", rd_a[2], 32'h308);

        // R4 source block of 2 then 20 idle cycles
        base = done_cnt;
        push_expect(32'h400, 32'hC00, 6, 2'd0, 2'd0);
        start_xfer(32'h400, 32'hC00, 6, 2'd0, 2'd0, 32'h0000_0214, 1'b0);
        wait_done(base + 1);
        check(rd_t[1] - rd_t[0] == 4, "R4 gap inside block", rd_t[1] - rd_t[0], 4);
        check(rd_t[2] - rd_t[1] == 22, "R4 idle after block", rd_t[2] - rd_t[1], 22);

        // R4 block size zero acts as one
        base = done_cnt;
        push_expect(32'h500, 32'hD00, 3, 2'd0, 2'd0);
        start_xfer(32'h500, 32'hD00, 3, 2'd0, 2'd0, 32'h0000_0005, 1'b0);
        wait_done(base + 1);
        check(rd_t[1] - rd_t[0] == 7, "R4 zero block size", rd_t[1] - rd_t[0], 7);

        // R5 destination block of 3 then 15 idle cycles
        base = done_cnt;
        push_expect(32'h600, 32'hE00, 4, 2'd0, 2'd0);
        start_xfer(32'h600, 32'hE00, 4, 2'd0, 2'd0, 32'h030F_0000, 1'b0);
        wait_done(base + 1);
        check(wr_t[2] - wr_t[1] == 4, "R5 gap inside block", wr_t[2] - wr_t[1], 4);
        check(wr_t[3] - wr_t[2] == 17, "R5 idle after block", wr_t[3] - wr_t[2], 17);

        // R6 busy waits for the first read; R2 frozen registers
        base = done_cnt;
        src_req = 1'b0;
        push_expect(32'h700, 32'hF00, 4, 2'd0, 2'd0);
        start_xfer(32'h700, 32'hF00, 4, 2'd0, 2'd0, 32'h0, 1'b0);
        repeat (10) @(negedge clk);
        reg_rd(5'h00, v); check(v[31:30] == 2'b10, "R6 started but not busy", v[31:30], 2'b10);
        check(rd_t.size() == 0, "R4 no read without request", rd_t.size(), 0);
        reg_wr(5'h04, 32'h0000_DEAD);
        reg_rd(5'h04, v); check(v == 32'h700, "R2 source frozen", v, 32'h700);
        reg_wr(5'h00, 32'h001F_0000);
        reg_rd(5'h00, v); check(v[20:16] == 5'h0, "R2 request type frozen", v[20:16], 0);
        src_req = 1'b1;
        repeat (4) @(negedge clk);
        reg_rd(5'h00, v); check(v[30] == 1'b1, "R6 busy while moving", v[30], 1);
        wait_done(base + 1);
        reg_rd(5'h00, v); check(v[31:30] == 2'b00, "R6 idle after pass", v[31:30], 0);

        // R7 continuous mode, stopped by clearing the bit mid-pass
        base = done_cnt;
        push_expect(32'h1000, 32'h2000, 2, 2'd0, 2'd0);
        push_expect(32'h1000, 32'h2000, 2, 2'd0, 2'd0);
        start_xfer(32'h1000, 32'h2000, 2, 2'd0, 2'd0, 32'h0, 1'b1);
        wait_done(base + 1);
        reg_wr(5'h00, 32'h0);
        wait_done(base + 2);
        repeat (12) @(negedge clk);
        check(done_cnt == base + 2, "R7 two passes", done_cnt, base + 2);
        check(exp_q.size() == 0, "R7 reloaded pass data", exp_q.size(), 0);
        reg_rd(5'h00, v); check(v[31] == 1'b0, "R7 start clears", v[31], 0);

        // R7 control write in the cycle of the final write acceptance
        base = done_cnt;
        push_expect(32'h3000, 32'h4000, 2, 2'd0, 2'd0);
        start_xfer(32'h3000, 32'h4000, 2, 2'd0, 2'd0, 32'h0, 1'b1);
        coll_arm = 1'b1;
        wait_done(base + 1);
        repeat (15) @(negedge clk);
        check(done_cnt == base + 1, "R7 same-cycle write wins", done_cnt, base + 1);
        reg_rd(5'h00, v); check(v[31] == 1'b0, "R7 start cleared on collision", v[31], 0);

        // R9 page modes refused
        base = done_cnt;
        rd_t.delete();
        reg_wr(5'h0C, 32'd2);
        reg_wr(5'h00, 32'h8000_0040);
        repeat (8) @(negedge clk);
        reg_rd(5'h00, v); check(v[31] == 1'b0, "R9 source page mode refused", v[31], 0);
        check(mode_err == 1'b1 && rd_t.size() == 0, "R9 mode error flagged", mode_err, 1);
        reg_wr(5'h00, 32'h8060_0000);
        reg_rd(5'h00, v); check(v[31] == 1'b0 && mode_err, "R9 destination page mode refused", v[31], 0);
        reg_wr(5'h00, 32'h0);
        check(mode_err == 1'b0, "R9 mode error cleared", mode_err, 0);

        // R10 zero count
        reg_wr(5'h0C, 32'd0);
        reg_wr(5'h00, 32'h8000_0000);
        repeat (3) @(negedge clk);
        reg_rd(5'h00, v); check(v[31] == 1'b0, "R10 start clears", v[31], 0);
        check(done_cnt == base && rd_t.size() == 0, "R10 no access", done_cnt, base);

        check(overlap == 0, "R11 no overlapping accesses", overlap, 0);
        finish_run();
    end

endmodule